// File: doc/BRIEF.md
# Platform System-Control Register Bridge

This block is a small byte-wide register file that sits on the I/O side of a legacy workstation chipset. A host access carries a 16-bit port number, a valid strobe and a read/write flag, and it completes in one cycle. The block holds a handful of platform controls: a soft-reset request, a little-endian mode flag, a disk-activity light, a 4-bit system-control field and a 1-bit I/O map type. It answers a set of fixed identification and status ports with constant bytes. Writes to two ports produce single-cycle lock-toggle pulses for an external NVRAM, and only when that NVRAM is reported present.

The block also translates a CPU offset inside the I/O window into an ISA port number. The map-type bit selects the translation. In flat mode the low 16 bits of the offset pass straight through. In sparse mode each 4 KB page of an 8 MB window carries 32 ports, so the page number supplies the upper port bits and the low five offset bits supply the lower ones.

Top module: `sysctl_bridge`

## Requirements
- R1: After synchronous reset, every writable control reads back as zero, the reset request, endian, light and both strobe outputs are low, the read data is 0x00, and translation is in flat mode.
- R2: A write to port 0x0092 sets the reset request output from data bit 0 and the endian flag from data bit 1, visible the cycle after the write. A read of 0x0092 returns the endian flag in bit 1 and zero in all other bits.
- R3: Ports 0x0800, 0x0802 and 0x0803 read 0xEF, 0xAD and 0xE0. Writes to them change no output and no readable value.
- R4: Ports 0x080C, 0x0810, 0x0818 and 0x0823 read 0x3C, 0x39, 0x00 and 0x03.
- R5: A write to port 0x0808 sets the light output from data bit 0, visible the cycle after the write.
- R6: A write to 0x0810 pulses lock strobe 1 high for exactly the one cycle after the write, and a write to 0x0812 does the same for lock strobe 2. Neither strobe pulses while the NVRAM-present input is low.
- R7: A write to port 0x081C stores data bits 3:0. A read returns them with bits 7:4 zero.
- R8: Port 0x0850 stores data bit 0 as the map type. A read returns it in bit 0 with bits 7:1 zero.
- R9: With map type 0, the translated port equals offset bits 15:0. With map type 1, it equals {offset[22:12], offset[4:0]}. The translation is combinational.
- R10: A read of any other port, including 0x0814, returns 0xFF, and the decode compares all 16 port bits. Writes to other ports change no state.
- R11: Read data is registered. It appears the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_port | input | 16 | Port number of the access |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Registered read data |
| nvram_present | input | 1 | High when the NVRAM is fitted |
| cpu_ofs | input | 23 | CPU offset inside the I/O window |
| io_port | output | 16 | Translated ISA port number |
| soft_reset | output | 1 | Soft-reset request |
| endian_le | output | 1 | Little-endian mode flag |
| light_on | output | 1 | Disk-activity light |
| lock_pulse1 | output | 1 | NVRAM lock-toggle strobe, bank 1 |
| lock_pulse2 | output | 1 | NVRAM lock-toggle strobe, bank 2 |

## Verification
The assertions check, on every cycle, several rules that relate outputs to earlier accesses. The reset request and the endian flag change only after a write to 0x0092. A lock strobe is high only after a matching write made while the NVRAM was present. The two strobes are never high together. An identification read returns its constant, and the system-control readback never carries upper bits. The bench's scenarios cover the rest. These are the full read-decode map, swept over every port up to 0x0FFF and a stride across the remaining 16-bit range. They also cover the arithmetic check of both translation modes over many offsets, the proof that ignored writes leave every readable value untouched, and the holding of read data between reads.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int PORT_W = 16;
  localparam int DATA_W = 8;

  localparam logic [PORT_W-1:0] P_RSTEND  = 16'h0092;
  localparam logic [PORT_W-1:0] P_ID_CPU  = 16'h0800;
  localparam logic [PORT_W-1:0] P_ID_FEAT = 16'h0802;
  localparam logic [PORT_W-1:0] P_ID_STAT = 16'h0803;
  localparam logic [PORT_W-1:0] P_LIGHT   = 16'h0808;
  localparam logic [PORT_W-1:0] P_EQUIP   = 16'h080C;
  localparam logic [PORT_W-1:0] P_LOCK1   = 16'h0810;
  localparam logic [PORT_W-1:0] P_LOCK2   = 16'h0812;
  localparam logic [PORT_W-1:0] P_KEYSW   = 16'h0818;
  localparam logic [PORT_W-1:0] P_SYSCTL  = 16'h081C;
  localparam logic [PORT_W-1:0] P_CACHE   = 16'h0823;
  localparam logic [PORT_W-1:0] P_MAPTYPE = 16'h0850;

  localparam logic [DATA_W-1:0] V_ID_CPU  = 8'hEF;
  localparam logic [DATA_W-1:0] V_ID_FEAT = 8'hAD;
  localparam logic [DATA_W-1:0] V_ID_STAT = 8'hE0;
  localparam logic [DATA_W-1:0] V_EQUIP   = 8'h3C;
  localparam logic [DATA_W-1:0] V_EXTFEAT = 8'h39;
  localparam logic [DATA_W-1:0] V_KEYSW   = 8'h00;
  localparam logic [DATA_W-1:0] V_CACHE   = 8'h03;
  localparam logic [DATA_W-1:0] V_NONE    = 8'hFF;

  typedef struct packed {
    logic       rst_req;
    logic       endian;
    logic       light;
    logic [3:0] sysval;
    logic       sparse;
  } ctrl_t;
endpackage

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int CTRL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PORT_W-1:0] port,
  input  logic [DATA_W-1:0] wdata,
  input  logic              nvram_present,
  output ctrl_t             ctrl,
  output logic              pulse1,
  output logic              pulse2
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      pulse1 <= 1'b0;
      pulse2 <= 1'b0;
    end else begin
      pulse1 <= wr_en && (port == P_LOCK1) && nvram_present;
      pulse2 <= wr_en && (port == P_LOCK2) && nvram_present;
      if (wr_en) begin
        case (port)
          P_RSTEND: begin
            ctrl.rst_req <= wdata[0];
            ctrl.endian  <= wdata[1];
          end
          P_LIGHT:   ctrl.light  <= wdata[0];
          P_SYSCTL:  ctrl.sysval <= wdata[CTRL_W-1:0];
          P_MAPTYPE: ctrl.sparse <= wdata[0];
          default: ;
        endcase
      end
    end
  end

  a_r2_reset_source: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctrl.rst_req) |-> $past(wr_en && port == P_RSTEND));
  a_r2_endian_source: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctrl.endian) |-> $past(wr_en && port == P_RSTEND));
  a_r6_pulse1_cause: assert property (@(posedge clk) disable iff (rst)
    pulse1 |-> $past(wr_en && port == P_LOCK1 && nvram_present));
  a_r6_pulse2_cause: assert property (@(posedge clk) disable iff (rst)
    pulse2 |-> $past(wr_en && port == P_LOCK2 && nvram_present));
  a_r6_pulses_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pulse1, pulse2}));
endmodule

// File: rtl/sysctl_readmux.sv
module sysctl_readmux
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [PORT_W-1:0] port,
  input  ctrl_t             ctrl,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    case (port)
      P_RSTEND:  sel = DATA_W'({ctrl.endian, 1'b0});
      P_ID_CPU:  sel = V_ID_CPU;
      P_ID_FEAT: sel = V_ID_FEAT;
      P_ID_STAT: sel = V_ID_STAT;
      P_EQUIP:   sel = V_EQUIP;
      P_LOCK1:   sel = V_EXTFEAT;
      P_KEYSW:   sel = V_KEYSW;
      P_SYSCTL:  sel = DATA_W'(ctrl.sysval);
      P_CACHE:   sel = V_CACHE;
      P_MAPTYPE: sel = DATA_W'(ctrl.sparse);
      default:   sel = V_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= sel;
  end

  a_r3_cpu_id: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && port == P_ID_CPU) |-> rdata == 8'hEF);
  a_r7_upper_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && port == P_SYSCTL) |-> rdata[7:4] == 4'h0);
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    $past(!rd_en) |-> $stable(rdata));
endmodule

// File: rtl/sysctl_xlate.sv
module sysctl_xlate
  import sysctl_pkg::*;
#(
  parameter int OFS_W   = 23,
  parameter int LOW_W   = 5,
  parameter int PAGE_LSB = 12
) (
  input  logic              sparse,
  input  logic [OFS_W-1:0]  ofs,
  output logic [PORT_W-1:0] io_port
);
  localparam int HI_W = PORT_W - LOW_W;

  always_comb begin
    if (sparse) io_port = {ofs[PAGE_LSB+HI_W-1:PAGE_LSB], ofs[LOW_W-1:0]};
    else        io_port = ofs[PORT_W-1:0];
  end
endmodule

// File: rtl/sysctl_bridge.sv
module sysctl_bridge
  import sysctl_pkg::*;
#(
  parameter int OFS_W  = 23,
  parameter int CTRL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [PORT_W-1:0] acc_port,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  input  logic              nvram_present,
  input  logic [OFS_W-1:0]  cpu_ofs,
  output logic [PORT_W-1:0] io_port,
  output logic              soft_reset,
  output logic              endian_le,
  output logic              light_on,
  output logic              lock_pulse1,
  output logic              lock_pulse2
);
  ctrl_t ctrl;

  sysctl_regs #(.CTRL_W(CTRL_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(acc_valid && acc_write), .port(acc_port),
    .wdata(acc_wdata), .nvram_present(nvram_present), .ctrl(ctrl),
    .pulse1(lock_pulse1), .pulse2(lock_pulse2)
  );

  sysctl_readmux u_rd (
    .clk(clk), .rst(rst), .rd_en(acc_valid && !acc_write), .port(acc_port),
    .ctrl(ctrl), .rdata(acc_rdata)
  );

  sysctl_xlate #(.OFS_W(OFS_W)) u_xl (
    .sparse(ctrl.sparse), .ofs(cpu_ofs), .io_port(io_port)
  );

  assign soft_reset = ctrl.rst_req;
  assign endian_le  = ctrl.endian;
  assign light_on   = ctrl.light;

  a_r9_flat_window: assert property (@(posedge clk) disable iff (rst)
    !ctrl.sparse |-> io_port == cpu_ofs[15:0]);
endmodule

// File: tb/tb_sysctl_bridge.sv
module tb_sysctl_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [15:0] acc_port = '0;
  logic [7:0]  acc_wdata = '0;
  logic [7:0]  acc_rdata;
  logic        nvram_present = 1'b1;
  logic [22:0] cpu_ofs = '0;
  logic [15:0] io_port;
  logic        soft_reset, endian_le, light_on, lock_pulse1, lock_pulse2;

  int checks = 0, errors = 0;
  logic       m_end = 0, m_map = 0;
  logic [3:0] m_sys = 0;

  always #10 clk = ~clk;

  sysctl_bridge dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] p, input logic [7:0] d);
    @(negedge clk); acc_valid = 1; acc_write = 1; acc_port = p; acc_wdata = d;
    @(negedge clk); acc_valid = 0; acc_write = 0;
    if (p == 16'h0092) m_end = d[1];
    if (p == 16'h081C) m_sys = d[3:0];
    if (p == 16'h0850) m_map = d[0];
  endtask

  task automatic rd(input logic [15:0] p);
    @(negedge clk); acc_valid = 1; acc_write = 0; acc_port = p;
    @(negedge clk); acc_valid = 0;
  endtask

  function automatic int exp_rd(input logic [15:0] p);
    case (p)
      16'h0092: return {m_end, 1'b0};
      16'h0800: return 8'hEF;
      16'h0802: return 8'hAD;
      16'h0803: return 8'hE0;
      16'h080C: return 8'h3C;
      16'h0810: return 8'h39;
      16'h0818: return 8'h00;
      16'h081C: return m_sys;
      16'h0823: return 8'h03;
      16'h0850: return m_map;
      default:  return 8'hFF;
    endcase
  endfunction

  task automatic sweep(input string tag);
    for (int p = 0; p < 4096; p++) begin
      rd(p[15:0]); chk(tag, acc_rdata, exp_rd(p[15:0]));
    end
    for (int p = 4096; p < 65536; p += 241) begin
      rd(p[15:0]); chk(tag, acc_rdata, exp_rd(p[15:0]));
    end
  endtask

  task automatic xlate_sweep();
    logic [22:0] s = 23'h1ACE5;
    for (int i = 0; i < 600; i++) begin
      s = {s[21:0], s[22] ^ s[17]};
      cpu_ofs = s ^ 23'(i * 4099);
      #1;
      if (m_map) chk("R9 sparse", io_port, (cpu_ofs & 'h1F) | ((cpu_ofs & 'h7FF000) >> 7));
      else       chk("R9 flat", io_port, cpu_ofs & 'hFFFF);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", acc_rdata, 0);
    chk("R1 outputs", {soft_reset, endian_le, light_on, lock_pulse1, lock_pulse2}, 0);
    cpu_ofs = 23'h7F_F123; #1;
    chk("R1 flat", io_port, 16'hF123);
    rd(16'h081C); chk("R1 sysctl", acc_rdata, 0);
    rd(16'h0850); chk("R1 maptype", acc_rdata, 0);
    rd(16'h0092); chk("R1 endian", acc_rdata, 0);

    // R2 combined reset / endian port
    wr(16'h0092, 8'h01); chk("R2 reset on", soft_reset, 1); chk("R2 endian", endian_le, 0);
    wr(16'h0092, 8'hFE); chk("R2 reset off", soft_reset, 0); chk("R2 endian on", endian_le, 1);
    rd(16'h0092); chk("R2 readback", acc_rdata, 8'h02);
    wr(16'h0092, 8'h03); chk("R2 both", {soft_reset, endian_le}, 3);
    wr(16'h0092, 8'h02);

    // R5 light
    wr(16'h0808, 8'h01); chk("R5 light on", light_on, 1);
    wr(16'h0808, 8'hFE); chk("R5 light off", light_on, 0);
    wr(16'h0808, 8'h03); chk("R5 light on2", light_on, 1);

    // R6 lock strobes
    wr(16'h0810, 8'h00); chk("R6 pulse1", {lock_pulse1, lock_pulse2}, 2'b10);
    @(negedge clk); chk("R6 pulse1 single", {lock_pulse1, lock_pulse2}, 0);
    wr(16'h0812, 8'h55); chk("R6 pulse2", {lock_pulse1, lock_pulse2}, 2'b01);
    @(negedge clk); chk("R6 pulse2 single", {lock_pulse1, lock_pulse2}, 0);
    nvram_present = 0;
    wr(16'h0810, 8'h00); chk("R6 gated1", {lock_pulse1, lock_pulse2}, 0);
    wr(16'h0812, 8'h00); chk("R6 gated2", {lock_pulse1, lock_pulse2}, 0);
    nvram_present = 1;

    // R7 system control, R8 map type
    wr(16'h081C, 8'hF5); rd(16'h081C); chk("R7 low nibble", acc_rdata, 8'h05);
    wr(16'h081C, 8'h3A); rd(16'h081C); chk("R7 low nibble2", acc_rdata, 8'h0A);
    wr(16'h0850, 8'hFE); rd(16'h0850); chk("R8 bit0 clear", acc_rdata, 0);
    xlate_sweep();
    wr(16'h0850, 8'h81); rd(16'h0850); chk("R8 bit0 set", acc_rdata, 1);
    xlate_sweep();
    cpu_ofs = 23'h40_2FFF; #1; chk("R9 sparse corner", io_port, 16'h805F);

    // R3 and R10: ignored writes leave state unchanged
    wr(16'h0800, 8'h00); wr(16'h0802, 8'h11); wr(16'h0803, 8'h22);
    wr(16'h0814, 8'hFF); wr(16'h0000, 8'hFF); wr(16'h8092, 8'h03);
    wr(16'hF81C, 8'h00); wr(16'h1850, 8'h00); wr(16'h080C, 8'h00);
    chk("R10 outputs kept", {soft_reset, endian_le, light_on}, 3'b011);
    rd(16'h0800); chk("R3 id cpu", acc_rdata, 8'hEF);
    rd(16'h0802); chk("R3 id feat", acc_rdata, 8'hAD);
    rd(16'h0803); chk("R3 id stat", acc_rdata, 8'hE0);
    rd(16'h081C); chk("R10 sysctl kept", acc_rdata, 8'h0A);
    rd(16'h0850); chk("R10 map kept", acc_rdata, 1);
    rd(16'h0814); chk("R10 invalidate port", acc_rdata, 8'hFF);
    rd(16'h080C); chk("R4 equip", acc_rdata, 8'h3C);
    rd(16'h0810); chk("R4 extfeat", acc_rdata, 8'h39);
    rd(16'h0818); chk("R4 keysw", acc_rdata, 8'h00);
    rd(16'h0823); chk("R4 cache", acc_rdata, 8'h03);

    // R11 latency and hold
    rd(16'h0823);
    repeat (3) @(negedge clk);
    chk("R11 hold idle", acc_rdata, 8'h03);
    wr(16'h0092, 8'h02); chk("R11 hold on write", acc_rdata, 8'h03);

    // full decode sweeps in two states (R3 R4 R10)
    sweep("R10 sweep A");
    wr(16'h0092, 8'h00); wr(16'h081C, 8'h0C); wr(16'h0850, 8'h00);
    sweep("R10 sweep B");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule